// File: doc/BRIEF.md
# Sync-Timed Active-Video Recovery

This block sits at the receiving end of a parallel RGB display bus that carries a pixel clock, a horizontal sync, a vertical sync and 24 colour bits, but no line that marks visible pixels. It counts pixel clocks from each horizontal sync leading edge, and lines from each vertical sync leading edge. From those counts and the programmed sync, porch and active widths it rebuilds an active-video flag and the column and row of every visible pixel.

The colour word, both syncs, the recovered flag and the coordinates leave the block through one register stage, with the same delay for all of them. A downstream line encoder can then use the flag to choose between pixel data and the two sync bits as control symbols. Colour is forced to zero outside the visible area. The block also measures every line and every frame it receives. If either length differs from the programmed total, it raises a sticky error flag, which a write-one-to-clear input drops.

All widths are parameters, and sync polarity is set per sync by a parameter. The defaults describe a 1280x720 mode: 1650 clocks per line, 750 lines per frame, about 74.25 MHz pixel clock, 60 Hz, both syncs active-high.

Top module: `de_recover`

## Requirements
- R1: While `rst_n` is low and afterwards until input arrives, `active_out`, `timing_err`, `rgb_out` and both sync outputs are 0.
- R2: `hsync_out`, `vsync_out` and, during active video, `rgb_out` equal the values on `hsync_in`, `vsync_in` and `rgb_in` two clock edges earlier.
- R3: The pixel index is 0 on the first clock where horizontal sync is asserted after being deasserted, and rises by 1 per clock. Visible columns are indices H_SYNC+H_BACK through H_SYNC+H_BACK+H_ACTIVE-1. `hpos` reports the index.
- R4: The line index advances at each horizontal sync leading edge. It is 0 on the line whose leading edge finds vertical sync asserted, when vertical sync was deasserted at the previous leading edge. Visible rows are indices V_SYNC+V_BACK through V_SYNC+V_BACK+V_ACTIVE-1. `vpos` reports the index.
- R5: `active_out` is 1 exactly for pixels inside both the visible columns and the visible rows. It stays 0 after reset until a vertical sync leading edge has been received.
- R6: When `active_out` is 0, `rgb_out` is 0.
- R7: At a horizontal sync leading edge after the first one, if the previous line was not H_TOTAL clocks long, `timing_err` becomes 1 and stays 1.
- R8: At a vertical sync leading edge after the first one, if the previous frame was not V_TOTAL lines long, `timing_err` becomes 1 and stays 1.
- R9: `err_clr` travels with the pixel sampled in the same clock. At output it clears `timing_err`, unless a new R7/R8 mismatch arrives at that same pixel; the new mismatch wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_in | input | 1 | Received horizontal sync, polarity per HS_POL |
| vsync_in | input | 1 | Received vertical sync, polarity per VS_POL |
| rgb_in | input | 24 | Received colour, red in [23:16], green [15:8], blue [7:0] |
| err_clr | input | 1 | Write-one-to-clear for `timing_err` |
| rgb_out | output | 24 | Colour, zero outside active video |
| hsync_out | output | 1 | Horizontal sync at received level, delayed |
| vsync_out | output | 1 | Vertical sync at received level, delayed |
| active_out | output | 1 | Recovered active-video flag |
| hpos | output | HCW | Pixel index within the line |
| vpos | output | VCW | Line index within the frame |
| timing_err | output | 1 | Sticky line/frame length mismatch |

## Verification
The assertions check four properties on every cycle:
- the two-edge delay of the syncs and of visible colour;
- zero colour whenever the flag is low;
- that a raised flag always sits inside the programmed column and row windows;
- that the error flag never drops without a clear request.

Other behaviour depends on whole scenarios, and only the bench's frame sweeps can show it. These scenarios are:
- the flag staying low until the first vertical sync edge;
- the exact position of every visible pixel over several frames;
- detection of a short line and of an over-long frame;
- a clear request that coincides with a fresh mismatch and must lose to it.

// File: rtl/de_recover_pkg.sv
// Shared types for the active-video recovery block.
// Assumes 8 bits per colour channel, red in the top byte.
package de_recover_pkg;
    typedef logic [7:0] chan_t;

    typedef struct packed {
        chan_t red;
        chan_t grn;
        chan_t blu;
    } pix_t;

    localparam int PIX_W = $bits(pix_t);

    // Counter width able to hold TOTAL plus a saturation headroom bit.
    function automatic int span_width(input int total);
        return $clog2(total + 1) + 1;
    endfunction
endpackage

// File: rtl/de_sync_front.sv
// Input register and sync edge detection.
// Captures the bus once per pixel clock and normalises sync polarity to active-high.
// It flags the horizontal sync leading edge, and flags a vertical sync leading edge
// found at a horizontal sync leading edge.
// Assumes vertical sync changes only near horizontal sync edges, as display timing does.
module de_sync_front
    import de_recover_pkg::*;
#(
    parameter bit HS_POL = 1'b1,
    parameter bit VS_POL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync_in,
    input  logic vsync_in,
    input  pix_t px_in,
    input  logic clr_in,
    output logic hs1,
    output logic vs1,
    output pix_t px1,
    output logic clr1,
    output logic hs_rise,
    output logic v_rise
);
    logic hs_act, vs_act;
    logic hs_prev_q;
    logic vs_line_q;

    // Polarity variant picked by parameter.
    generate
        if (HS_POL) begin : g_hs_hi
            assign hs_act = hs1;
        end else begin : g_hs_lo
            assign hs_act = ~hs1;
        end
        if (VS_POL) begin : g_vs_hi
            assign vs_act = vs1;
        end else begin : g_vs_lo
            assign vs_act = ~vs1;
        end
    endgenerate

    // Capture one pixel of the incoming bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs1  <= ~HS_POL;
            vs1  <= ~VS_POL;
            px1  <= '0;
            clr1 <= 1'b0;
        end else begin
            hs1  <= hsync_in;
            vs1  <= vsync_in;
            px1  <= px_in;
            clr1 <= clr_in;
        end
    end

    // Remember the previous normalised horizontal sync level.
    always_ff @(posedge clk) begin
        if (!rst_n) hs_prev_q <= 1'b0;
        else        hs_prev_q <= hs_act;
    end

    // Remember the vertical sync level seen at the last line start.
    always_ff @(posedge clk) begin
        if (!rst_n)       vs_line_q <= 1'b0;
        else if (hs_rise) vs_line_q <= vs_act;
    end

    assign hs_rise = hs_act & ~hs_prev_q;
    assign v_rise  = hs_rise & vs_act & ~vs_line_q;
endmodule

// File: rtl/de_span_counter.sv
// Position counter for one axis (pixels in a line or lines in a frame).
// `restart` zeroes the index and `step` advances it; the index saturates.
// The module reports whether the index lies in the visible window, and flags a
// restart whose previous span was not TOTAL long.
// Assumes restart implies step for the vertical use.
module de_span_counter #(
    parameter int TOTAL = 1650,
    parameter int START = 260,
    parameter int LEN   = 1280,
    parameter int CW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          restart,
    output logic [CW-1:0] idx,
    output logic          in_win,
    output logic          len_err
);
    localparam logic [CW-1:0] MAX_V  = '1;
    localparam logic [CW-1:0] TOT_V  = CW'(TOTAL);
    localparam logic [CW-1:0] WIN_LO = CW'(START);
    localparam logic [CW-1:0] WIN_HI = CW'(START + LEN);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] inc;
    logic          lock_q;
    logic          locked;

    // Next index: zero at restart, saturating increment on step.
    always_comb begin
        inc = (cnt_q == MAX_V) ? MAX_V : cnt_q + 1'b1;
        if (restart)   idx = '0;
        else if (step) idx = inc;
        else           idx = cnt_q;
    end

    // Hold the index and note that a first restart has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= MAX_V;
            lock_q <= 1'b0;
        end else begin
            cnt_q  <= idx;
            lock_q <= lock_q | restart;
        end
    end

    assign locked  = lock_q | restart;
    assign in_win  = locked && (idx >= WIN_LO) && (idx < WIN_HI);
    assign len_err = restart && lock_q && (inc != TOT_V);
endmodule

// File: rtl/de_out_stage.sv
// Output register: aligns colour, syncs, active flag, coordinates and the sticky
// timing error behind one common register. Colour is blanked outside active video.
// Assumes all inputs come from the same pixel in the capture stage.
module de_out_stage
    import de_recover_pkg::*;
#(
    parameter int HCW = 12,
    parameter int VCW = 11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pix_t           px1,
    input  logic           hs1,
    input  logic           vs1,
    input  logic           act1,
    input  logic [HCW-1:0] hidx,
    input  logic [VCW-1:0] vidx,
    input  logic           mismatch,
    input  logic           clr1,
    output pix_t           px_out,
    output logic           hs_out,
    output logic           vs_out,
    output logic           act_out,
    output logic [HCW-1:0] hpos,
    output logic [VCW-1:0] vpos,
    output logic           err_out
);
    // Register the aligned pixel record, blanking colour outside active video.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_out  <= '0;
            hs_out  <= 1'b0;
            vs_out  <= 1'b0;
            act_out <= 1'b0;
            hpos    <= '0;
            vpos    <= '0;
        end else begin
            px_out  <= act1 ? px1 : '0;
            hs_out  <= hs1;
            vs_out  <= vs1;
            act_out <= act1;
            hpos    <= hidx;
            vpos    <= vidx;
        end
    end

    // Sticky error: a new mismatch wins over a clear request.
    always_ff @(posedge clk) begin
        if (!rst_n) err_out <= 1'b0;
        else        err_out <= mismatch | (err_out & ~clr1);
    end
endmodule

// File: rtl/de_recover.sv
// Top: recovers active video and pixel coordinates from sync timing alone.
// Pipeline: capture register, then output register (two edges in to out).
// Assumes the programmed widths match the source mode. Mismatches are reported,
// and no attempt is made to adapt to a different mode.
module de_recover
    import de_recover_pkg::*;
#(
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 110,
    parameter int H_SYNC   = 40,
    parameter int H_BACK   = 220,
    parameter int V_ACTIVE = 720,
    parameter int V_FRONT  = 5,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 20,
    parameter bit HS_POL   = 1'b1,
    parameter bit VS_POL   = 1'b1,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HCW     = span_width(H_TOTAL),
    localparam int VCW     = span_width(V_TOTAL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hsync_in,
    input  logic           vsync_in,
    input  logic [23:0]    rgb_in,
    input  logic           err_clr,
    output logic [23:0]    rgb_out,
    output logic           hsync_out,
    output logic           vsync_out,
    output logic           active_out,
    output logic [HCW-1:0] hpos,
    output logic [VCW-1:0] vpos,
    output logic           timing_err
);
    pix_t           px1, px_o;
    logic           hs1, vs1, clr1, hs_rise, v_rise;
    logic [HCW-1:0] hidx;
    logic [VCW-1:0] vidx;
    logic           h_win, v_win, h_err, v_err;
    logic           act1;

    de_sync_front #(
        .HS_POL (HS_POL),
        .VS_POL (VS_POL)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .hsync_in (hsync_in),
        .vsync_in (vsync_in),
        .px_in    (pix_t'(rgb_in)),
        .clr_in   (err_clr),
        .hs1      (hs1),
        .vs1      (vs1),
        .px1      (px1),
        .clr1     (clr1),
        .hs_rise  (hs_rise),
        .v_rise   (v_rise)
    );

    de_span_counter #(
        .TOTAL (H_TOTAL),
        .START (H_SYNC + H_BACK),
        .LEN   (H_ACTIVE),
        .CW    (HCW)
    ) u_hcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (1'b1),
        .restart (hs_rise),
        .idx     (hidx),
        .in_win  (h_win),
        .len_err (h_err)
    );

    de_span_counter #(
        .TOTAL (V_TOTAL),
        .START (V_SYNC + V_BACK),
        .LEN   (V_ACTIVE),
        .CW    (VCW)
    ) u_vcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (hs_rise),
        .restart (v_rise),
        .idx     (vidx),
        .in_win  (v_win),
        .len_err (v_err)
    );

    assign act1 = h_win & v_win;

    de_out_stage #(
        .HCW (HCW),
        .VCW (VCW)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .px1      (px1),
        .hs1      (hs1),
        .vs1      (vs1),
        .act1     (act1),
        .hidx     (hidx),
        .vidx     (vidx),
        .mismatch (h_err | v_err),
        .clr1     (clr1),
        .px_out   (px_o),
        .hs_out   (hsync_out),
        .vs_out   (vsync_out),
        .act_out  (active_out),
        .hpos     (hpos),
        .vpos     (vpos),
        .err_out  (timing_err)
    );

    assign rgb_out = px_o;
endmodule

// File: rtl/de_recover_chk.sv
// Checker for de_recover: per-cycle properties on its ports, bound below.
module de_recover_chk #(
    parameter int H_ACTIVE = 1280,
    parameter int H_SYNC   = 40,
    parameter int H_BACK   = 220,
    parameter int V_ACTIVE = 720,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 20,
    parameter int HCW      = 12,
    parameter int VCW      = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hsync_in,
    input logic           vsync_in,
    input logic [23:0]    rgb_in,
    input logic           err_clr,
    input logic [23:0]    rgb_out,
    input logic           hsync_out,
    input logic           vsync_out,
    input logic           active_out,
    input logic [HCW-1:0] hpos,
    input logic [VCW-1:0] vpos,
    input logic           timing_err
);
    localparam logic [HCW-1:0] H_LO = HCW'(H_SYNC + H_BACK);
    localparam logic [HCW-1:0] H_HI = HCW'(H_SYNC + H_BACK + H_ACTIVE);
    localparam logic [VCW-1:0] V_LO = VCW'(V_SYNC + V_BACK);
    localparam logic [VCW-1:0] V_HI = VCW'(V_SYNC + V_BACK + V_ACTIVE);

    logic [1:0] age;

    // Count edges since reset, saturating, to gate $past lookups.
    always_ff @(posedge clk) begin
        if (!rst_n)         age <= 2'd0;
        else if (age != 3)  age <= age + 2'd1;
    end

    assert_sync_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2) |-> (hsync_out == $past(hsync_in, 2) && vsync_out == $past(vsync_in, 2)));

    assert_rgb_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2 && active_out) |-> (rgb_out == $past(rgb_in, 2)));

    assert_blank_rgb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !active_out |-> (rgb_out == 24'h0));

    assert_hwindow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active_out |-> (hpos >= H_LO && hpos < H_HI));

    assert_vwindow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        active_out |-> (vpos >= V_LO && vpos < V_HI));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2 && $past(timing_err) && !$past(err_clr, 2)) |-> timing_err);
endmodule

bind de_recover de_recover_chk #(
    .H_ACTIVE (H_ACTIVE),
    .H_SYNC   (H_SYNC),
    .H_BACK   (H_BACK),
    .V_ACTIVE (V_ACTIVE),
    .V_SYNC   (V_SYNC),
    .V_BACK   (V_BACK),
    .HCW      (HCW),
    .VCW      (VCW)
) u_chk (.*);

// File: tb/de_recover_test.sv
// Bench: sweeps every pixel of several small frames and predicts each output arithmetically.
module de_recover_test;
    localparam int HA = 8, HFP = 2, HSW = 3, HBP = 4;
    localparam int VA = 4, VFP = 1, VSW = 2, VBP = 2;
    localparam int HT = HA + HFP + HSW + HBP;
    localparam int VT = VA + VFP + VSW + VBP;
    localparam int HCW = $clog2(HT + 1) + 1;
    localparam int VCW = $clog2(VT + 1) + 1;

    typedef struct packed {
        logic        act;
        logic        hs;
        logic        vs;
        logic        err;
        logic [1:0]  etag;
        logic [23:0] rgb;
        logic [7:0]  x;
        logic [7:0]  y;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           hsync_in = 1'b0, vsync_in = 1'b0, err_clr = 1'b0;
    logic [23:0]    rgb_in = '0;
    logic [23:0]    rgb_out;
    logic           hsync_out, vsync_out, active_out, timing_err;
    logic [HCW-1:0] hpos;
    logic [VCW-1:0] vpos;

    int   tests = 0, fails = 0;
    int   gy = 5, frame_len = VT, lines_since = 0, last_line = 0;
    bit   hseen = 0, vseen = 0, exp_err = 0, old_v = 0, new_v = 0;
    exp_t h_old, h_new;
    logic [7:0] pcnt = 8'd0;

    always #5 clk = ~clk;

    de_recover #(
        .H_ACTIVE (HA), .H_FRONT (HFP), .H_SYNC (HSW), .H_BACK (HBP),
        .V_ACTIVE (VA), .V_FRONT (VFP), .V_SYNC (VSW), .V_BACK (VBP)
    ) uut (
        .clk (clk), .rst_n (rst_n), .hsync_in (hsync_in), .vsync_in (vsync_in),
        .rgb_in (rgb_in), .err_clr (err_clr), .rgb_out (rgb_out),
        .hsync_out (hsync_out), .vsync_out (vsync_out), .active_out (active_out),
        .hpos (hpos), .vpos (vpos), .timing_err (timing_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // One pixel: compare the pixel driven two negedges ago, then drive a new one.
    task automatic step(input int x, input int y, input bit clr, input int prev_frame);
        bit ev_l, ev_f, act;
        exp_t e;
        @(negedge clk);
        if (old_v) begin
            check("R5 active", int'(active_out), int'(h_old.act));
            if (h_old.act) check("R2 rgb", int'(rgb_out), int'(h_old.rgb));
            else           check("R6 rgb blank", int'(rgb_out), 0);
            check("R2 hsync", int'(hsync_out), int'(h_old.hs));
            check("R2 vsync", int'(vsync_out), int'(h_old.vs));
            case (h_old.etag)
                2'd1:    check("R8 err", int'(timing_err), int'(h_old.err));
                2'd2:    check("R9 err", int'(timing_err), int'(h_old.err));
                default: check("R7 err", int'(timing_err), int'(h_old.err));
            endcase
            if (h_old.act) begin
                check("R3 hpos", int'(hpos), int'(h_old.x));
                check("R4 vpos", int'(vpos), int'(h_old.y));
            end
        end
        ev_l = (x == 0) && hseen && (last_line != HT);
        if (x == 0) hseen = 1;
        ev_f = (x == 0) && (y == 0) && vseen && (prev_frame != VT);
        if (x == 0 && y == 0) vseen = 1;
        act = vseen && x >= HSW + HBP && x < HSW + HBP + HA
                    && y >= VSW + VBP && y < VSW + VBP + VA;
        exp_err = ev_l | ev_f | (exp_err & ~clr);
        pcnt = pcnt + 8'd1;
        e.act  = act;
        e.hs   = (x < HSW);
        e.vs   = (y < VSW);
        e.err  = exp_err;
        e.etag = ev_f ? 2'd1 : (clr ? 2'd2 : 2'd0);
        e.rgb  = {8'(y * 17), 8'(x * 13), pcnt};
        e.x    = 8'(x);
        e.y    = 8'(y);
        h_old = h_new; old_v = new_v;
        h_new = e;     new_v = 1;
        hsync_in = e.hs;
        vsync_in = e.vs;
        rgb_in   = e.rgb;
        err_clr  = clr;
    endtask

    task automatic run_line(input int len, input int clr_at);
        int pf;
        pf = lines_since;
        if (gy == 0) lines_since = 0;
        for (int x = 0; x < len; x++) step(x, gy, (x == clr_at), pf);
        last_line = len;
        lines_since++;
        gy++;
        if (gy >= frame_len) gy = 0;
    endtask

    task automatic run_lines(input int n);
        for (int i = 0; i < n; i++) run_line(HT, -1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 active", int'(active_out), 0);
        check("R1 err", int'(timing_err), 0);
        check("R1 rgb", int'(rgb_out), 0);
        check("R1 hsync", int'(hsync_out), 0);
        rst_n = 1'b1;
        // Start mid-frame: R5 requires active to stay low until vsync edge.
        run_lines((VT - 5) + 2 * VT);
        // R7: short line, then R9 clear coinciding with new mismatch, then real clear.
        run_lines(5);
        run_line(HT - 3, -1);
        run_line(HT, 0);
        run_line(HT, -1);
        run_line(HT, 5);
        while (gy != 0) run_line(HT, -1);
        // R8: one frame with an extra line
        frame_len = VT + 1;
        run_lines(VT + 1);
        frame_len = VT;
        run_lines(2);
        run_line(HT, 3);
        run_lines(VT - 3);
        run_lines(VT);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog R1: got hung run expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule